// File: doc/BRIEF.md
# Read-Triggered Sleep-State Request Controller

This block sits behind an I/O-mapped register port and turns reads into low-power requests for the clock-control logic. Three byte registers share one aligned dword. The dword starts at a programmable base address plus 0x14. Reading one of these registers does not return data. Instead, the read starts a C2, C3 or C4 request, and that request is held until a break event arrives. While any request is held, the active-low stop-clock output is driven low. A two-bit level output shows which state the sequencer is in.

Accesses arrive as dword requests with byte enables. A single access can therefore touch more than one trigger byte. When it does, the shallowest requested level wins. A configuration input maps the level-3 request onto C4.

The port uses a valid/ready handshake for requests and a valid/ready handshake for responses. Only one response can be outstanding. `req_ready` is high when no response is pending, or when the pending response is being taken in the same cycle (`!rsp_valid || rsp_ready`). An accepted request produces `rsp_valid` on the next cycle. The response stays valid until `rsp_ready` is seen. Every response carries zero data.

Top module: `sleep_req_ctrl`

## Requirements
- R1: After an active-low reset, `cur_level` is 0 (RUN), `stpclk_n` is 1 and `rsp_valid` is 0.
- R2: An accepted read in RUN with byte enable 0 set, to the dword at {base[15:2],00}+0x14, makes `cur_level` 1 (C2) and `stpclk_n` 0 after the next clock edge.
- R3: An accepted read in RUN with only byte enable 1 of that dword set enters level 2 (C3) when `c4_on_c3` is 0, and level 3 (C4) when it is 1.
- R4: An accepted read in RUN with only byte enable 2 of that dword set enters level 3 (C4).
- R5: Every response returns `rsp_rdata` = 0. A write, including one to the trigger dword, never changes the level.
- R6: A non-RUN level is held until `brk_evt` is sampled high. After that edge, `cur_level` is 0 and `stpclk_n` is 1. `stpclk_n` is 0 exactly when `cur_level` is not 0.
- R7: When `brk_evt` is high in the same cycle as an accepted trigger read, the result is RUN.
- R8: A trigger read accepted while `cur_level` is not 0 leaves the level unchanged. The read is still answered with zero data.
- R9: When one read sets several trigger byte enables, the shallowest level wins. Lane 0 beats lane 1, and lane 1 beats lane 2. The `c4_on_c3` remap applies to the lane-1 result.
- R10: `throttle_out` equals `thr_en | thr_force`, except in level 1 (C2), where it is 0.
- R11: `req_ready` = `!rsp_valid || rsp_ready`. `rsp_valid` rises in the cycle after acceptance and stays high until a cycle with `rsp_ready` high.
- R12: Reads outside the trigger dword, reads with only byte enable 3 set, and requests not accepted leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_addr | input | 16 | Programmable base; bits 1:0 ignored |
| c4_on_c3 | input | 1 | Remap level-3 reads to C4 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address; bits 1:0 ignored |
| req_be | input | 4 | Byte enables for the dword |
| req_wdata | input | 32 | Write data (discarded) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Response data, always zero |
| brk_evt | input | 1 | Break event, returns to RUN |
| thr_en | input | 1 | Throttle enable |
| thr_force | input | 1 | Forced throttle |
| throttle_out | output | 1 | Throttle request to clock control |
| stpclk_n | output | 1 | Active-low stop-clock |
| cur_level | output | 2 | 0 RUN, 1 C2, 2 C3, 3 C4 |

## Verification
Two pairs of events can land on the same clock edge. A break event can coincide with an accepted trigger read. Two or three trigger lanes can be set in one read. Directed steps drive each pair together, with and without the C3-to-C4 remap, and the random phase keeps hitting both pairs by running frequent breaks and random byte enables. A reference model in the bench predicts the level after each edge from the break-first, shallowest-lane-first rule and compares it against `cur_level` and `stpclk_n`.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    LV_RUN = 2'd0,
    LV_C2  = 2'd1,
    LV_C3  = 2'd2,
    LV_C4  = 2'd3
  } lvl_e;

  // byte offset of the first trigger register above the base
  localparam int unsigned TRIG_OFS = 32'h14;
  localparam int unsigned N_TRIG   = 3;

  // trigger lane k requests this level (before any remap)
  function automatic lvl_e lane_level(input int unsigned k);
    case (k)
      0:       return LV_C2;
      1:       return LV_C3;
      default: return LV_C4;
    endcase
  endfunction
endpackage

// File: rtl/slp_rsp.sv
module slp_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic rv_q;

  assign req_ready = !rv_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = rv_q;
  assign rsp_rdata = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rv_q <= 1'b0;
    else if (accept)    rv_q <= 1'b1;
    else if (rsp_ready) rv_q <= 1'b0;
  end
endmodule

// File: rtl/slp_decode.sv
module slp_decode import slp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int BE_W   = 4
) (
  input  logic              accept,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [ADDR_W-1:0] base,
  output logic [N_TRIG-1:0] hit
);
  localparam int LSB_W = $clog2(BE_W);
  localparam int HI_W  = ADDR_W - LSB_W;

  logic [HI_W-1:0] trig_hi;
  logic            dw_match;
  logic            rd_acc;
  logic            unused_lo;

  assign trig_hi   = base[ADDR_W-1:LSB_W] + HI_W'(TRIG_OFS / BE_W);
  assign dw_match  = (addr[ADDR_W-1:LSB_W] == trig_hi);
  assign rd_acc    = accept && !we;
  assign unused_lo = ^{addr[LSB_W-1:0], base[LSB_W-1:0], be};

  for (genvar k = 0; k < N_TRIG; k++) begin : g_lane
    localparam int LANE = (TRIG_OFS + k) % BE_W;
    assign hit[k] = rd_acc && dw_match && be[LANE];
  end
endmodule

// File: rtl/slp_pick.sv
module slp_pick import slp_pkg::*; (
  input  logic [N_TRIG-1:0] hit,
  input  logic              c4_on_c3,
  output logic              trig,
  output lvl_e              trig_lvl
);
  always_comb begin
    trig     = |hit;
    trig_lvl = LV_C4;
    for (int k = N_TRIG - 1; k >= 0; k--) begin
      if (hit[k]) trig_lvl = lane_level(k);
    end
    if (trig_lvl == LV_C3 && c4_on_c3) trig_lvl = LV_C4;
  end
endmodule

// File: rtl/slp_seq.sv
module slp_seq import slp_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  lvl_e       trig_lvl,
  input  logic       brk,
  input  logic       thr_en,
  input  logic       thr_force,
  output logic [1:0] level,
  output logic       stpclk_n,
  output logic       throttle_out
);
  lvl_e lvl_q, lvl_d;
  logic stop_n_q;

  always_comb begin
    lvl_d = lvl_q;
    if (brk)                        lvl_d = LV_RUN;
    else if (lvl_q == LV_RUN && trig) lvl_d = trig_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= LV_RUN;
      stop_n_q <= 1'b1;
    end else begin
      lvl_q    <= lvl_d;
      stop_n_q <= (lvl_d == LV_RUN);
    end
  end

  assign level        = lvl_q;
  assign stpclk_n     = stop_n_q;
  assign throttle_out = (thr_en || thr_force) && (lvl_q != LV_C2);
endmodule

// File: rtl/sleep_req_ctrl.sv
module sleep_req_ctrl import slp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int BE_W   = 4,
  parameter int DATA_W = 8 * BE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              c4_on_c3,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              brk_evt,
  input  logic              thr_en,
  input  logic              thr_force,
  output logic              throttle_out,
  output logic              stpclk_n,
  output logic [1:0]        cur_level
);
  logic              accept;
  logic [N_TRIG-1:0] hit;
  logic              trig;
  lvl_e              trig_lvl;
  logic              unused_wdata;

  assign unused_wdata = ^req_wdata;

  slp_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  slp_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .accept(accept), .we(req_we), .addr(req_addr), .be(req_be),
    .base(base_addr), .hit(hit)
  );

  slp_pick u_pick (
    .hit(hit), .c4_on_c3(c4_on_c3), .trig(trig), .trig_lvl(trig_lvl)
  );

  slp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_lvl(trig_lvl),
    .brk(brk_evt), .thr_en(thr_en), .thr_force(thr_force),
    .level(cur_level), .stpclk_n(stpclk_n), .throttle_out(throttle_out)
  );
endmodule

// File: rtl/slp_chk.sv
module slp_chk #(
  parameter int ADDR_W = 16,
  parameter int BE_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] base_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BE_W-1:0]   req_be,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              brk_evt,
  input logic              throttle_out,
  input logic              stpclk_n,
  input logic [1:0]        cur_level
);
  localparam int LSB_W = $clog2(BE_W);
  localparam int HI_W  = ADDR_W - LSB_W;

  logic rd_acc, in_dw;
  assign rd_acc = req_valid && req_ready && !req_we;
  assign in_dw  = (req_addr[ADDR_W-1:LSB_W] ==
                   HI_W'(base_addr[ADDR_W-1:LSB_W] + HI_W'(32'h14 / BE_W)));

  // R2: lane 0 read from RUN lands in C2
  a_r2_enter_c2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && in_dw && req_be[0] && cur_level == 2'd0 && !brk_evt) |=> cur_level == 2'd1);
  // R6: break returns to RUN and releases stop-clock
  a_r6_break_run: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> (cur_level == 2'd0 && stpclk_n));
  // R6: stop-clock follows the level
  a_r6_stop_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    stpclk_n == (cur_level == 2'd0));
  // R8: a held level does not move without a break
  a_r8_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level != 2'd0 && !brk_evt) |=> $stable(cur_level));
  // R10: no throttle while in C2
  a_r10_no_thr_c2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level == 2'd1 |-> !throttle_out);
  // R11: back-pressure blocks new requests and holds the response
  a_r11_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);
  // R5: response data is zero
  a_r5_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata == '0);
  // R12: no level change from RUN without an accepted read
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd0 && !rd_acc) |=> cur_level == 2'd0);
endmodule

bind sleep_req_ctrl slp_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .req_valid(req_valid),
  .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr), .req_be(req_be),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .brk_evt(brk_evt), .throttle_out(throttle_out), .stpclk_n(stpclk_n),
  .cur_level(cur_level)
);

// File: tb/tb_sleep_req_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_req_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base_addr = 16'h0400;
  logic        c4_on_c3 = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        brk_evt = 1'b0, thr_en = 1'b0, thr_force = 1'b0;
  logic        req_ready, rsp_valid, throttle_out, stpclk_n;
  logic [31:0] rsp_rdata;
  logic [1:0]  cur_level;

  always #2.5 clk = ~clk;

  sleep_req_ctrl dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .c4_on_c3(c4_on_c3),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .brk_evt(brk_evt), .thr_en(thr_en), .thr_force(thr_force),
    .throttle_out(throttle_out), .stpclk_n(stpclk_n), .cur_level(cur_level)
  );

  int    n_chk = 0, n_bad = 0;
  int    m_lvl = 0;
  bit    m_rv = 1'b0;
  string lvl_tag = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] trig_dw(input logic [15:0] b);
    return {b[15:2], 2'b00} + 16'h0014;
  endfunction

  // level requested by a read, 0 when none
  function automatic int pick(input logic [15:0] a, input logic [3:0] be,
                              input logic [15:0] b, input bit c4);
    if (a[15:2] != trig_dw(b)[15:2]) return 0;
    if (be[0]) return 1;
    if (be[1]) return c4 ? 3 : 2;
    if (be[2]) return 3;
    return 0;
  endfunction

  task automatic step(input bit v, input bit we, input logic [15:0] a,
                      input logic [3:0] be, input bit brk, input bit rdy,
                      input bit te, input bit tf);
    bit acc;
    int p;
    @(negedge clk);
    req_valid = v; req_we = we; req_addr = a; req_be = be;
    req_wdata = $urandom; brk_evt = brk; rsp_ready = rdy;
    thr_en = te; thr_force = tf;
    #1;
    chk(lvl_tag, int'(cur_level), m_lvl);
    chk({lvl_tag, " stpclk"}, int'(stpclk_n), (m_lvl == 0) ? 1 : 0);
    chk("R11 rsp_valid", int'(rsp_valid), int'(m_rv));
    if (m_rv) chk("R5 rdata", int'(rsp_rdata != 0), 0);
    chk("R11 req_ready", int'(req_ready), int'(!m_rv || rdy));
    chk("R10 throttle", int'(throttle_out), ((te || tf) && m_lvl != 1) ? 1 : 0);
    acc = v && (!m_rv || rdy);
    p = (acc && !we) ? pick(a, be, base_addr, c4_on_c3) : 0;
    if (brk && p != 0)           lvl_tag = "R7";
    else if (brk)                lvl_tag = "R6";
    else if (m_lvl != 0 && p != 0) lvl_tag = "R8";
    else if (m_lvl != 0)         lvl_tag = "R6";
    else if (p != 0 && $countones(be[2:0]) > 1) lvl_tag = "R9";
    else if (p == 1)             lvl_tag = "R2";
    else if (p != 0 && be[1])    lvl_tag = "R3";
    else if (p == 3)             lvl_tag = "R4";
    else if (acc && we)          lvl_tag = "R5";
    else                         lvl_tag = "R12";
    if (brk) m_lvl = 0;
    else if (m_lvl == 0 && p != 0) m_lvl = p;
    m_rv = acc ? 1'b1 : (m_rv && !rdy);
  endtask

  task automatic rd(input logic [3:0] be);
    step(1, 0, trig_dw(base_addr), be, 0, 1, 0, 0);
  endtask
  task automatic brk();
    step(0, 0, '0, '0, 1, 1, 0, 0);
  endtask
  task automatic idle(input bit te, input bit tf);
    step(0, 0, '0, '0, 0, 1, te, tf);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(cur_level), 0);
    chk("R1 stpclk", int'(stpclk_n), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    idle(0, 0);
    rd(4'b0001); idle(1, 0); idle(0, 1);     // R2 then R10 in C2
    rd(4'b0100); idle(0, 0); brk(); idle(1, 1); // R8 hold, R6 release
    rd(4'b0010); idle(0, 0); brk();          // R3 without remap
    c4_on_c3 = 1'b1;
    rd(4'b0010); idle(0, 0); brk();          // R3 with remap
    c4_on_c3 = 1'b0;
    rd(4'b0100); idle(0, 0); brk();          // R4
    rd(4'b0011); idle(0, 0); brk();          // R9 lane 0 beats lane 1
    rd(4'b0110); idle(0, 0); brk();          // R9 lane 1 beats lane 2
    c4_on_c3 = 1'b1;
    rd(4'b0111); idle(0, 0); brk();
    rd(4'b0110); idle(0, 0); brk();
    c4_on_c3 = 1'b0;
    step(1, 0, trig_dw(base_addr), 4'b0001, 1, 1, 0, 0); idle(0, 0); // R7
    step(1, 1, trig_dw(base_addr), 4'b1111, 0, 1, 0, 0); idle(0, 0); // R5
    step(1, 0, trig_dw(base_addr) + 16'h4, 4'b1111, 0, 1, 0, 0); idle(0, 0); // R12
    rd(4'b1000); idle(0, 0);                 // R12 lane 3
    step(1, 0, 16'h0000, 4'b0001, 0, 0, 0, 0); // R11 back-pressure
    step(1, 0, trig_dw(base_addr), 4'b0001, 0, 0, 0, 0);
    step(1, 0, trig_dw(base_addr), 4'b0001, 0, 0, 0, 0);
    step(0, 0, '0, '0, 0, 1, 0, 0); idle(0, 0); brk();
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] a;
      if (i % 1000 == 0) begin
        @(negedge clk);
        base_addr = 16'($urandom) & 16'hFFFC;
        c4_on_c3  = 1'($urandom);
      end
      a = ($urandom % 4 != 0) ? (trig_dw(base_addr) | 16'($urandom % 4))
                              : 16'($urandom);
      step(($urandom % 3) != 0, ($urandom % 5) == 0, a, 4'($urandom),
           ($urandom % 6) == 0, ($urandom % 4) != 0, 1'($urandom), 1'($urandom));
    end
    summary();
  end
endmodule